// File: doc/BRIEF.md
# Non-Maskable Interrupt Pending Controller

This block takes an asynchronous non-maskable interrupt pin and turns each rising edge into a request to the processor core. The request carries a fixed vector of 2. That vector comes from inside the block, so the core never runs an acknowledge bus cycle to fetch it. The core accepts a request with an acknowledge strobe, which marks a handler as running. It ends the handler with a one-cycle return strobe.

Edges that arrive while a request is outstanding or a handler is running are folded into a single pending flag. The return strobe releases that flag as a fresh request. Any further edges in that window are dropped.

A strap input is captured on the cycle in which reset is released. A low strap means the local interrupt controller is hardware disabled. In that mode the pin no longer raises non-maskable requests. Its synchronized level is passed out as a plain local interrupt line instead.

Top module: `nmi_pend_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `nmi_req`, `in_service` and `pending` are 0.
- R2: With the block enabled and idle, a 0-to-1 change on `nmi_pin` sets `nmi_req` on the third rising clock edge after the pin changes: two synchronizer flops plus the request flop.
- R3: A pin held high produces only one request. A new request needs the pin to go low and then high again.
- R4: `nmi_vector` is 8'h02 whenever `nmi_req` is 1 and 8'h00 otherwise.
- R5: `nmi_ack` while `nmi_req` is 1 clears `nmi_req` and sets `in_service` on the next cycle.
- R6: An edge seen while a request is outstanding or `in_service` is 1 sets `pending` and does not raise `nmi_req`.
- R7: At most one edge is held. Edges seen while `pending` is already 1 and no return occurs are discarded.
- R8: `iret_pulse` while `in_service` is 1 clears `in_service` on the next cycle. If `pending` was 1, the same cycle also raises `nmi_req` and clears `pending`.
- R9: An edge processed in the same cycle as an accepted `iret_pulse` is not lost. With `pending` 0 it raises `nmi_req` at once. With `pending` 1 the held edge raises `nmi_req` and the new edge stays in `pending`.
- R10: `strap_in` low on the last cycle of reset sets `local_ctrl_off`. In that mode `nmi_req` stays 0, and `local_irq_out` follows `nmi_pin` two clock edges later.
- R11: `strap_in` high at reset release keeps `local_ctrl_off` 0 and `local_irq_out` 0. Changes on `strap_in` after reset have no effect until the next reset.
- R12: `nmi_ack` with `nmi_req` at 0, and `iret_pulse` with `in_service` at 0, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| strap_in | input | 1 | Controller enable strap, sampled at reset release (low = disabled) |
| nmi_ack | input | 1 | Core accepts the request |
| iret_pulse | input | 1 | One-cycle return-from-handler strobe |
| nmi_req | output | 1 | Request to the core |
| nmi_vector | output | VEC_W | Vector presented with the request |
| in_service | output | 1 | A handler is running |
| pending | output | 1 | One edge is held for later delivery |
| local_ctrl_off | output | 1 | Local interrupt controller is hardware disabled |
| local_irq_out | output | 1 | Synchronized pin level in disabled mode, else 0 |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and an 8-bit vector of value 2. With these values the pin-to-request latency is a fixed three cycles. That fixed latency lets a cycle table place an edge exactly on the cycle of a return strobe, both with and without a held request. Each row of the table also checks the vector. Directed runs then cover both strap values, a reset taken mid-service, and a strap change after reset.

// File: rtl/nmi_pend_pkg.sv
package nmi_pend_pkg;
  localparam int unsigned DEF_VEC_W = 8;
  localparam int unsigned DEF_NMI_VEC = 2;

  // rising-edge detect between consecutive synchronized samples
  function automatic logic rise_detect(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // vector driven with a request, zero otherwise
  function automatic logic [DEF_VEC_W-1:0] vec_out(input logic req);
    return req ? DEF_VEC_W'(DEF_NMI_VEC) : '0;
  endfunction
endpackage

// File: rtl/nmi_pin_sync.sv
module nmi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic sync_lvl,
  output logic rise_evt
);
  import nmi_pend_pkg::*;

  logic [STAGES-1:0] chain_q;
  logic prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign sync_lvl = chain_q[STAGES-1];
  assign rise_evt = rise_detect(sync_lvl, prev_q);

  // R3: an edge event never repeats on consecutive cycles
  a_r3_single_edge: assert property (@(posedge clk) disable iff (rst)
    rise_evt |=> !rise_evt);
endmodule

// File: rtl/nmi_strap_latch.sv
module nmi_strap_latch (
  input  logic clk,
  input  logic rst,
  input  logic strap_in,
  output logic ctrl_off
);
  logic strap_q;

  // tracks the strap while reset is held; the last reset cycle wins
  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_in;
  end

  assign ctrl_off = ~strap_q;

  // R11: the captured mode does not move outside reset
  a_r11_strap_held: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(ctrl_off));
endmodule

// File: rtl/nmi_service_fsm.sv
module nmi_service_fsm (
  input  logic clk,
  input  logic rst,
  input  logic edge_in,
  input  logic ack,
  input  logic iret,
  output logic req,
  output logic svc,
  output logic pend
);
  logic req_q, svc_q, pend_q;
  logic req_d, svc_d, pend_d;
  logic ack_hit, ret_hit, busy;

  assign ack_hit = ack & req_q;
  assign ret_hit = iret & svc_q;
  assign busy    = req_q | svc_q;

  always_comb begin
    req_d  = req_q;
    svc_d  = svc_q;
    pend_d = pend_q;
    if (ack_hit) begin
      req_d = 1'b0;
      svc_d = 1'b1;
    end
    if (ret_hit) begin
      svc_d = 1'b0;
      if (pend_q) begin
        req_d  = 1'b1;
        pend_d = 1'b0;
      end
    end
    if (edge_in) begin
      if (ret_hit) begin
        if (pend_q) pend_d = 1'b1;
        else        req_d  = 1'b1;
      end else if (busy) begin
        pend_d = 1'b1;
      end else begin
        req_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      svc_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      svc_q  <= svc_d;
      pend_q <= pend_d;
    end
  end

  assign req  = req_q;
  assign svc  = svc_q;
  assign pend = pend_q;

  // R2: an edge while idle raises the request next cycle
  a_r2_idle_edge: assert property (@(posedge clk) disable iff (rst)
    edge_in && !req_q && !svc_q |=> req_q);
  // R5: acknowledge moves the request into service
  a_r5_ack_service: assert property (@(posedge clk) disable iff (rst)
    ack && req_q |=> !req_q && svc_q);
  // R6: an edge during service is held, not delivered
  a_r6_hold_edge: assert property (@(posedge clk) disable iff (rst)
    edge_in && svc_q && !iret |=> pend_q && !req_q);
  // R8: return with a held edge releases it
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    iret && svc_q && pend_q |=> req_q && !svc_q);
  // R3: every new request has a cause
  a_r3_req_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> $past(edge_in) || $past(iret && pend_q));
  // R7: a held edge only exists beside outstanding work
  a_r7_pend_context: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> req_q || svc_q);
endmodule

// File: rtl/nmi_pend_ctrl.sv
module nmi_pend_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VEC_W = nmi_pend_pkg::DEF_VEC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_pin,
  input  logic             strap_in,
  input  logic             nmi_ack,
  input  logic             iret_pulse,
  output logic             nmi_req,
  output logic [VEC_W-1:0] nmi_vector,
  output logic             in_service,
  output logic             pending,
  output logic             local_ctrl_off,
  output logic             local_irq_out
);
  import nmi_pend_pkg::*;

  logic sync_lvl, rise_evt, take_edge;

  nmi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(nmi_pin),
    .sync_lvl(sync_lvl), .rise_evt(rise_evt)
  );

  nmi_strap_latch u_strap (
    .clk(clk), .rst(rst), .strap_in(strap_in), .ctrl_off(local_ctrl_off)
  );

  assign take_edge = rise_evt & ~local_ctrl_off;

  nmi_service_fsm u_fsm (
    .clk(clk), .rst(rst), .edge_in(take_edge), .ack(nmi_ack),
    .iret(iret_pulse), .req(nmi_req), .svc(in_service), .pend(pending)
  );

  assign nmi_vector    = VEC_W'(vec_out(nmi_req));
  assign local_irq_out = local_ctrl_off & sync_lvl;

  // R4: vector tracks the request
  a_r4_vector: assert property (@(posedge clk) disable iff (rst)
    nmi_req |-> nmi_vector == VEC_W'(DEF_NMI_VEC));
  // R10: disabled mode never requests
  a_r10_no_req_off: assert property (@(posedge clk) disable iff (rst)
    local_ctrl_off |-> !nmi_req && !pending);
  // R11: enabled mode keeps the local line quiet
  a_r11_line_quiet: assert property (@(posedge clk) disable iff (rst)
    !local_ctrl_off |-> !local_irq_out);
  // R1: reset clears all service state
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> !nmi_req && !in_service && !pending);
endmodule

// File: tb/nmi_pend_ctrl_tb_top.sv
module nmi_pend_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst, nmi_pin, strap_in, nmi_ack, iret_pulse;
  logic nmi_req, in_service, pending, local_ctrl_off, local_irq_out;
  logic [7:0] nmi_vector;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nmi_pend_ctrl dut_i (
    .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .strap_in(strap_in),
    .nmi_ack(nmi_ack), .iret_pulse(iret_pulse), .nmi_req(nmi_req),
    .nmi_vector(nmi_vector), .in_service(in_service), .pending(pending),
    .local_ctrl_off(local_ctrl_off), .local_irq_out(local_irq_out)
  );

  // row fields: pin ack iret | exp_req exp_svc exp_pend
  localparam logic [5:0] STEPS [0:38] = '{
    6'b100000, 6'b100000, 6'b100100, 6'b110010, 6'b000010,
    6'b000010, 6'b100010, 6'b000010, 6'b100011, 6'b100011,
    6'b100011, 6'b101100, 6'b110010, 6'b101000, 6'b111000,
    6'b000000, 6'b000000, 6'b100000, 6'b100000, 6'b100100,
    6'b010010, 6'b000010, 6'b000010, 6'b100010, 6'b100010,
    6'b101100, 6'b110010, 6'b000010, 6'b000010, 6'b100010,
    6'b000010, 6'b000011, 6'b100011, 6'b000011, 6'b001101,
    6'b010011, 6'b001100, 6'b010010, 6'b001000
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst = 1'b1; strap_in = strap; nmi_pin = 1'b0; nmi_ack = 1'b0; iret_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic step(input logic p, input logic a, input logic r);
    @(negedge clk);
    nmi_pin = p; nmi_ack = a; iret_pulse = r;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; strap_in = 1'b1; nmi_pin = 1'b0; nmi_ack = 1'b0; iret_pulse = 1'b0;
    do_reset(1'b1);
    // R1: state after reset release
    check("R1 req after reset", nmi_req, 0);
    check("R1 svc after reset", in_service, 0);
    check("R1 pend after reset", pending, 0);
    check("R11 mode enabled", local_ctrl_off, 0);

    // table covers R2 R3 R4 R5 R6 R7 R8 R9 R12
    for (int i = 0; i < 39; i++) begin
      step(STEPS[i][5], STEPS[i][4], STEPS[i][3]);
      check($sformatf("R2/R5/R6/R8 req row %0d", i), nmi_req, STEPS[i][2]);
      check($sformatf("R5/R8/R12 svc row %0d", i), in_service, STEPS[i][1]);
      check($sformatf("R6/R7/R9 pend row %0d", i), pending, STEPS[i][0]);
      check($sformatf("R4 vector row %0d", i), nmi_vector, STEPS[i][2] ? 8'h02 : 8'h00);
    end

    // R1: reset taken in the middle of service
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    check("R5 in service before reset", in_service, 1);
    do_reset(1'b1);
    check("R1 svc cleared mid-run", in_service, 0);
    check("R1 req cleared mid-run", nmi_req, 0);

    // R11: strap change after reset is ignored
    @(negedge clk); strap_in = 1'b0;
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    check("R11 mode held after strap change", local_ctrl_off, 0);
    check("R11 local line quiet", local_irq_out, 0);
    check("R2 request still works", nmi_req, 1);

    // R10: disabled mode
    do_reset(1'b0);
    check("R10 mode disabled", local_ctrl_off, 1);
    step(1'b1, 1'b0, 1'b0);
    check("R10 line one edge in", local_irq_out, 0);
    step(1'b1, 1'b0, 1'b0);
    check("R10 line follows pin", local_irq_out, 1);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    check("R10 no request", nmi_req, 0);
    check("R10 no pending", pending, 0);
    step(1'b0, 1'b0, 1'b0);
    check("R10 line falls", local_irq_out, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule